// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C-compatible target that lets a bus host read and write a small bank of 8-bit registers. The block samples the SCL and SDA lines through a two-flop synchronizer on a system clock that runs much faster than SCL. From the synchronized lines it detects SCL edges, START, repeated START and STOP. It answers a fixed 7-bit device address. It takes a subaddress byte that loads a register pointer, and it moves the pointer forward after each data byte. This allows burst writes, and burst reads that use a repeated START. It acknowledges by pulling SDA low through `sda_oe`, an open-drain enable. At all other times it leaves SDA released.

The lower registers of the bank are control registers. Each one drives a byte of `ctrl_o` and reads back its stored value. The upper registers are read-only and return bytes of `status_i`. The control registers return to their defaults asynchronously whenever `supply_ok` goes low.

The sequencing lives in one state machine with these states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_SUB`: shifting in the subaddress.
- `ST_SUB_ACK`: acknowledging the subaddress.
- `ST_WDATA`: shifting in a data byte.
- `ST_WDATA_ACK`: acknowledging a data byte.
- `ST_RDATA`: shifting out a byte.
- `ST_RACK`: sampling the host's acknowledge.
- `ST_IGNORE`: not participating until the next START or STOP.

The transitions are as follows:
- START forces `ST_ADDR` from any state.
- STOP forces `ST_IDLE` from any state.
- A complete byte moves a receive state to its acknowledge state, or to `ST_IGNORE` when the byte is refused.
- The SCL fall that ends an acknowledge slot moves on:
  - from `ST_ADDR_ACK` to `ST_SUB` for a write, or to `ST_RDATA` for a read;
  - from `ST_SUB_ACK` to `ST_WDATA`;
  - from `ST_WDATA_ACK` back to `ST_WDATA`.
- In `ST_RDATA`, the fall after the eighth bit moves to `ST_RACK`.
- In `ST_RACK`, the fall moves to `ST_RDATA` when the host acknowledged, and to `ST_IGNORE` when it did not.

Top module: `i2c_reg_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 0010100 (0x28 for a write, 0x29 for a read, R/W in bit 0). For any other address it leaves SDA released for the rest of the transfer, until a START or STOP, and changes no register.
- R2: A subaddress below 5 is acknowledged and becomes the register pointer. A subaddress of 5 or more is not acknowledged.
- R3: In a write, every data byte sent to an in-range pointer is acknowledged. It is stored if it targets a control register, and the pointer then moves up by one, so a burst fills consecutive registers.
- R4: After a write-phase subaddress, a repeated START and address 0x29, the target returns the register at the pointer, MSB first. It then returns consecutive registers for as long as the host acknowledges.
- R5: When the host does not acknowledge a read byte, the target releases SDA and sends nothing more until a START or STOP.
- R6: Once the pointer has passed the last register, a written data byte is not acknowledged and a read byte returns 0x00.
- R7: Registers 0 to 2 are control registers: they drive `ctrl_o[8i+7:8i]` and read back their stored values. Registers 3 and 4 return `status_i[7:0]` and `status_i[15:8]`. A write to them is acknowledged and has no effect.
- R8: While `supply_ok` is low, the control registers hold their defaults: 0x0A, 0x05 and 0x3C for registers 0, 1 and 2.
- R9: A START or STOP in the middle of a byte ends the transfer without changing any register. The pointer is kept, and a START begins a fresh address byte.
- R10: `sda_oe` changes only while SCL is low.
- R11: After reset, `sda_oe` is 0 and `ctrl_o` holds the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply valid; low resets the control registers |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| status_i | input | 16 | Read-only register contents (registers 3, 4) |
| ctrl_o | output | 24 | Control register contents (registers 0 to 2) |

## Verification
The hardest situations to reach are the ones after the target has stopped taking part: a host NACK, a refused address, or a pointer that has run past the end. In each of these, the only visible evidence is that SDA stays high while the host keeps clocking. The stimulus therefore continues to clock whole bytes after each refusal, and checks that the line reads all ones and that `ctrl_o` is unchanged. The aborts are produced by stopping the bit sequence after three or four bits and issuing STOP or a repeated START at that point. A following read then shows that the pointer survived the abort.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // [0] metastability stage, [1] synchronized, [2] one cycle older
    logic [2:0] scl_pipe;
    logic [2:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= 3'b111;
            sda_pipe <= 3'b111;
        end else begin
            scl_pipe <= {scl_pipe[1:0], scl_i};
            sda_pipe <= {sda_pipe[1:0], sda_i};
        end
    end

    assign scl_s     = scl_pipe[1];
    assign sda_s     = sda_pipe[1];
    assign scl_rise  = scl_pipe[1] & ~scl_pipe[2];
    assign scl_fall  = ~scl_pipe[1] & scl_pipe[2];
    assign start_det = scl_pipe[1] & scl_pipe[2] & sda_pipe[2] & ~sda_pipe[1];
    assign stop_det  = scl_pipe[1] & scl_pipe[2] & ~sda_pipe[2] & sda_pipe[1];

endmodule

// File: rtl/i2c_tgt_regbank.sv
module i2c_tgt_regbank #(
    parameter int                      NUM_CTRL   = 3,
    parameter int                      NUM_STAT   = 2,
    parameter logic [NUM_CTRL*8-1:0]   CTRL_RESET = 24'h3C_05_0A
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  supply_ok,
    input  logic                  wr_en,
    input  logic [7:0]            wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_idx,
    output logic [7:0]            rd_data,
    input  logic [NUM_STAT*8-1:0] status_i,
    output logic [NUM_CTRL*8-1:0] ctrl_o
);
    localparam int NUM_REGS = NUM_CTRL + NUM_STAT;

    logic bank_rst_n;
    assign bank_rst_n = rst_n & supply_ok;

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
        logic [7:0] q;
        always_ff @(posedge clk or negedge bank_rst_n) begin
            if (!bank_rst_n) begin
                q <= CTRL_RESET[g*8 +: 8];
            end else if (wr_en && wr_idx == 8'(g)) begin
                q <= wr_data;
            end
        end
        assign ctrl_o[g*8 +: 8] = q;
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (rd_idx == 8'(i)) rd_data = ctrl_o[i*8 +: 8];
        end
        for (int j = 0; j < NUM_STAT; j++) begin
            if (rd_idx == 8'(NUM_CTRL + j)) rd_data = status_i[j*8 +: 8];
        end
        if (rd_idx >= 8'(NUM_REGS)) rd_data = 8'h00;
    end

    // R8: defaults held while the supply is not valid
    a_r8_supply_default: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> (ctrl_o == CTRL_RESET));

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h14,
    parameter int         NUM_REGS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [7:0] ptr,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    localparam int         CNT_W    = $clog2(BYTE_BITS + 1);
    localparam logic [7:0] REG_END  = 8'(NUM_REGS);

    tgt_state_t        state, nxt;
    logic [CNT_W-1:0]  bitcnt;
    logic [7:0]        shreg;
    logic [7:0]        tx_q;
    logic              is_read;
    logic              host_ack;
    logic              byte_done;
    logic              ptr_ok;
    logic              addr_hit;
    logic [7:0]        ptr_inc;

    assign byte_done = (bitcnt == CNT_W'(BYTE_BITS));
    assign ptr_ok    = (ptr < REG_END);
    assign addr_hit  = (shreg[7:1] == DEV_ADDR);
    assign ptr_inc   = ptr_ok ? ptr + 8'd1 : ptr;
    assign wr_data   = shreg;

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else if (scl_fall) begin
            unique case (state)
                ST_ADDR:      if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  nxt = is_read ? ST_RDATA : ST_SUB;
                ST_SUB:       if (byte_done) nxt = (shreg < REG_END) ? ST_SUB_ACK : ST_IGNORE;
                ST_SUB_ACK:   nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = ptr_ok ? ST_WDATA_ACK : ST_IGNORE;
                ST_WDATA_ACK: nxt = ST_WDATA;
                ST_RDATA:     if (byte_done) nxt = ST_RACK;
                ST_RACK:      nxt = host_ack ? ST_RDATA : ST_IGNORE;
                default:      nxt = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // byte datapath: shifters, bit counter, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            shreg    <= 8'h00;
            tx_q     <= 8'h00;
            is_read  <= 1'b0;
            host_ack <= 1'b0;
            ptr      <= 8'h00;
        end else if (start_det || stop_det) begin
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (scl_rise && !byte_done) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (scl_fall && byte_done) begin
                        if (state == ST_ADDR) is_read <= shreg[0];
                        if (state == ST_SUB && shreg < REG_END) ptr <= shreg;
                        if (state == ST_WDATA && ptr_ok) ptr <= ptr + 8'd1;
                    end
                end
                ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR_ACK && is_read) begin
                            tx_q <= rd_data;
                            ptr  <= ptr_inc;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) bitcnt <= bitcnt + 1'b1;
                    if (scl_fall && !byte_done) tx_q <= {tx_q[6:0], 1'b0};
                end
                ST_RACK: begin
                    if (scl_rise) host_ack <= ~sda_s;
                    if (scl_fall && host_ack) begin
                        bitcnt <= '0;
                        tx_q   <= rd_data;
                        ptr    <= ptr_inc;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        wr_en  = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA: sda_oe = ~tx_q[7];
            ST_WDATA: wr_en = scl_fall && byte_done && ptr_ok;
            default: ;
        endcase
    end

    // R1 / R5: a non-participating target leaves the line alone
    a_r5_ignore_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe);
    // R9: START always restarts the address phase
    a_r9_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_det && !stop_det |=> (state == ST_ADDR && bitcnt == '0));
    // R9: STOP always returns to idle
    a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));
    // R10: the driver only moves while SCL is low
    a_r10_oe_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));
    // R2: a data phase never starts beyond the bank end
    a_r2_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA || state == ST_WDATA_ACK) |-> (ptr <= REG_END));

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
    parameter logic [6:0]            DEV_ADDR   = 7'h14,
    parameter int                    NUM_CTRL   = 3,
    parameter int                    NUM_STAT   = 2,
    parameter logic [NUM_CTRL*8-1:0] CTRL_RESET = 24'h3C_05_0A
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  supply_ok,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic [NUM_STAT*8-1:0] status_i,
    output logic [NUM_CTRL*8-1:0] ctrl_o
);
    localparam int NUM_REGS = NUM_CTRL + NUM_STAT;

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] ptr, rd_data, wr_data;
    logic       wr_en;

    i2c_tgt_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    i2c_tgt_regbank #(
        .NUM_CTRL   (NUM_CTRL),
        .NUM_STAT   (NUM_STAT),
        .CTRL_RESET (CTRL_RESET)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .wr_en     (wr_en),
        .wr_idx    (ptr),
        .wr_data   (wr_data),
        .rd_idx    (ptr),
        .rd_data   (rd_data),
        .status_i  (status_i),
        .ctrl_o    (ctrl_o)
    );

endmodule

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;

    localparam int Q = 10;                 // clk cycles per quarter SCL period
    localparam logic [23:0] DEF = 24'h3C_05_0A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        supply_ok = 1'b1;
    logic        scl_h = 1'b1;
    logic        sda_h = 1'b1;
    logic [15:0] status_i = 16'hC3_7E;
    logic        sda_oe;
    logic [23:0] ctrl_o;
    logic        sda_line;

    int checks = 0;
    int errors = 0;
    int oe_viol = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_q[$];

    always #4 clk = ~clk;                  // 125 MHz

    assign sda_line = sda_h & ~sda_oe;

    i2c_reg_target u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .scl_i     (scl_h),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .status_i  (status_i),
        .ctrl_o    (ctrl_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();     // also a repeated START from SCL low
        sda_h = 1'b1; qwait();
        scl_h = 1'b1; qwait();
        sda_h = 1'b0; qwait();
        scl_h = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; qwait();
        scl_h = 1'b1; qwait();
        sda_h = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_h = b; qwait();
        scl_h = 1'b1; qwait(); qwait();
        scl_h = 1'b0; qwait();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_h = 1'b1; qwait();
        scl_h = 1'b1; qwait();
        ack = ~sda_line; qwait();
        scl_h = 1'b0; qwait();
    endtask

    task automatic read_byte(input logic host_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_h = 1'b1; qwait();
            scl_h = 1'b1; qwait();
            d[i] = sda_line; qwait();
            scl_h = 1'b0; qwait();
        end
        send_bit(~host_ack);
        sda_h = 1'b1;
    endtask

    // driver for reads: pushes expected bytes, monitor compares
    task automatic expect_byte(input logic [7:0] b, input string tag);
        exp_q.push_back(b);
        tag_q.push_back(tag);
    endtask

    task automatic rd_burst(input logic [7:0] sub, input int n);
        logic a;
        logic [7:0] d;
        bus_start();
        write_byte(8'h28, a); chk("R1 read-phase address ack", a, 1);
        write_byte(sub, a);   chk("R2 read-phase subaddress ack", a, 1);
        bus_start();
        write_byte(8'h29, a); chk("R4 read address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, d);
            got_q.push_back(d);
        end
        bus_stop();
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (got_q.size() > 0) begin
                logic [7:0] g;
                g = got_q.pop_front();
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected read byte", g, 8'hxx);
                end else begin
                    chk(tag_q.pop_front(), g, exp_q.pop_front());
                end
            end
        end
    end

    // R10: watch the driver against the raw SCL level
    logic prev_scl = 1'b1, prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_h && prev_scl && sda_oe !== prev_oe) oe_viol++;
        prev_scl <= scl_h;
        prev_oe  <= sda_oe;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic a;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        // R11 reset state
        chk("R11 sda_oe after reset", sda_oe, 0);
        chk("R11 ctrl defaults", ctrl_o, DEF);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R3 write two bytes from register 0
        bus_start();
        write_byte(8'h28, a); chk("R1 write address ack", a, 1);
        write_byte(8'h00, a); chk("R2 subaddress 0 ack", a, 1);
        write_byte(8'hA1, a); chk("R3 data ack reg0", a, 1);
        write_byte(8'h55, a); chk("R3 data ack reg1", a, 1);
        bus_stop();
        chk("R3 ctrl after burst", ctrl_o, 24'h3C_55_A1);

        // R3/R7 burst from 1 crossing into a status register
        bus_start();
        write_byte(8'h28, a);
        write_byte(8'h01, a); chk("R2 subaddress 1 ack", a, 1);
        write_byte(8'h11, a); chk("R3 ack reg1", a, 1);
        write_byte(8'h22, a); chk("R3 ack reg2", a, 1);
        write_byte(8'h99, a); chk("R7 ack write to status reg", a, 1);
        bus_stop();
        chk("R7 ctrl unchanged by status write", ctrl_o, 24'h22_11_A1);

        // R4/R7 read all five registers
        expect_byte(8'hA1, "R4 read reg0");
        expect_byte(8'h11, "R4 read reg1");
        expect_byte(8'h22, "R4 read reg2");
        expect_byte(8'h7E, "R7 read status reg3");
        expect_byte(8'hC3, "R7 read status reg4");
        rd_burst(8'h00, 5);

        // R6 read past the end
        expect_byte(8'hC3, "R6 read reg4");
        expect_byte(8'h00, "R6 read past end");
        rd_burst(8'h04, 2);

        // R6 write past the end
        bus_start();
        write_byte(8'h28, a);
        write_byte(8'h04, a);
        write_byte(8'h44, a); chk("R6 ack last register", a, 1);
        write_byte(8'h45, a); chk("R6 nack past end", a, 0);
        bus_stop();

        // R2 out-of-range subaddress
        bus_start();
        write_byte(8'h28, a);
        write_byte(8'h05, a); chk("R2 subaddress 5 nack", a, 0);
        write_byte(8'h66, a); chk("R2 data after refused sub", a, 0);
        bus_stop();

        // R1 foreign address
        bus_start();
        write_byte(8'h30, a); chk("R1 foreign address nack", a, 0);
        write_byte(8'h00, a); chk("R1 ignored sub nack", a, 0);
        write_byte(8'hEE, a); chk("R1 ignored data nack", a, 0);
        bus_stop();
        chk("R1 ctrl unchanged", ctrl_o, 24'h22_11_A1);

        // R5 host NACK ends transmission
        bus_start();
        write_byte(8'h28, a);
        write_byte(8'h03, a);
        bus_start();
        write_byte(8'h29, a);
        read_byte(1'b0, d); chk("R5 byte before nack", d, 8'h7E);
        read_byte(1'b0, d); chk("R5 line released after nack", d, 8'hFF);
        bus_stop();

        // R9 STOP mid-byte
        bus_start();
        write_byte(8'h28, a);
        write_byte(8'h00, a);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        chk("R9 stop mid-byte no write", ctrl_o, 24'h22_11_A1);

        // R9 repeated START mid-byte keeps the pointer
        bus_start();
        write_byte(8'h28, a);
        write_byte(8'h02, a);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        write_byte(8'h29, a); chk("R9 address after restart", a, 1);
        read_byte(1'b0, d); chk("R9 pointer kept", d, 8'h22);
        bus_stop();
        chk("R9 ctrl after restart abort", ctrl_o, 24'h22_11_A1);

        // R8 supply drop
        supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 defaults while supply low", ctrl_o, DEF);
        supply_ok = 1'b1;
        repeat (3) @(negedge clk);
        expect_byte(8'h0A, "R8 reg0 default readback");
        rd_burst(8'h00, 1);

        repeat (20) @(negedge clk);
        chk("R10 sda_oe stable while SCL high", oe_viol, 0);
        chk("R4 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule